// File: doc/BRIEF.md
# Frame-Synced Stereo Serial Audio Port

This block is the digital side of a link to an audio codec that acts as bus master. The codec drives the bit clock and two active-low frame syncs, one for capture and one for playback. The port never drives any of them. Each frame holds two 16-bit words back to back, left first and then right. The port shifts both words in from the converter's capture line and shifts two words out on the playback line.

Every captured word is placed at the bottom of a 32-bit receive register, with its sign bit copied into the upper half. A one-cycle receive pulse reports that the word is there. Playback words come from a holding register that is written through a strobe. All four codec lines pass through two-flop synchronisers into the system clock domain. The port finds bit-clock rising edges there and does all of its work on them.

Top module: `sap_port`

## Requirements
- R1: After reset, `rx_data` is 0 and `rx_irq`, `rx_overrun`, `tx_underrun` and `dac_sd` are all 0.
- R2: A bit-clock rising edge on which the capture frame sync is low, while the receiver is idle, starts a frame. The next 32 rising edges each take one bit from `adc_sd`. Words arrive MSB first, left word then right word.
- R3: A completed word appears in `rx_data[15:0]`, and `rx_data[31:16]` each equal its bit 15.
- R4: `rx_irq` is high for exactly one system clock cycle per completed word. In that cycle `rx_slot` is 0 for the left word and 1 for the right word.
- R5: If a word completes while the previous word has not been acknowledged by `rx_rd`, `rx_overrun` pulses together with `rx_irq`, and the new word replaces the old one in `rx_data`.
- R6: On a bit-clock rising edge where the playback frame sync is low and the transmitter is idle, the held word is loaded. Its MSB is on `dac_sd` by the next rising edge. The 32 bits of the left and right words then follow, one per rising edge, MSB first.
- R7: Each word load that finds no `tx_wr` since the previous load sends the held word again and pulses `tx_underrun` for one cycle.
- R8: While no frame is in progress, toggling the bit clock with the frame syncs high produces no `rx_irq`, and `dac_sd` stays 0.
- R9: `rx_data` changes only in a cycle where `rx_irq` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bclk | input | 1 | Bit clock from the codec |
| rx_fs_n | input | 1 | Capture frame sync, active low |
| tx_fs_n | input | 1 | Playback frame sync, active low |
| adc_sd | input | 1 | Serial capture data from the codec |
| dac_sd | output | 1 | Serial playback data to the codec |
| tx_wr | input | 1 | Write strobe for the playback holding register |
| tx_data | input | 16 | Playback word to hold |
| rx_rd | input | 1 | Acknowledge of the current received word |
| rx_data | output | 32 | Sign-extended received word |
| rx_irq | output | 1 | One-cycle pulse when a word has been received |
| rx_slot | output | 1 | 0 for the left word, 1 for the right word |
| rx_overrun | output | 1 | Pulse: an unacknowledged word was overwritten |
| tx_underrun | output | 1 | Pulse: a word was reloaded without a new write |

## Verification
Captured samples include 0x7FFF, 0x8000, 0xFFFE and 0x0001. A design that zero-pads, or that copies the wrong bit upward, gives a wrong upper half. A design that samples one edge early or late shifts every word by one bit, which also breaks the split between left and right.

The bench leaves the right playback word unwritten, and then leaves a whole frame unwritten. A design that sends stale data silently, or flags the wrong load, shows up in the playback bits or in the count of underrun pulses.

Reads are withheld across two frames to provoke overruns, and `rx_data` must then hold the newest word. Idle bit clocks with the syncs high must create neither a receive pulse nor any playback activity.

// File: rtl/sap_pkg.sv
package sap_pkg;
    parameter int unsigned SAMPLE_W = 16;
    parameter int unsigned RXREG_W  = 32;
    parameter int unsigned SLOTS    = 2;
    parameter int unsigned SYNC_STAGES = 2;
endpackage

// File: rtl/sap_sync.sv
module sap_sync #(
    parameter int unsigned W      = 4,
    parameter int unsigned STAGES = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);
    logic [STAGES-1:0][W-1:0] stage_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage_q <= {STAGES{RST_VAL}};
        end else begin
            stage_q[0] <= async_in;
            for (int i = 1; i < STAGES; i++) begin
                stage_q[i] <= stage_q[i-1];
            end
        end
    end

    assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/sap_rx.sv
module sap_rx #(
    parameter int unsigned WORD_W = 16,
    parameter int unsigned REG_W  = 32,
    parameter int unsigned WORDS  = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_rise,
    input  logic fs_low,
    input  logic sd,
    input  logic rd,
    output logic [REG_W-1:0] word,
    output logic irq,
    output logic [$clog2(WORDS)-1:0] slot,
    output logic overrun
);
    localparam int unsigned FRAME_BITS = WORD_W * WORDS;
    localparam int unsigned CNT_W  = $clog2(FRAME_BITS);
    localparam int unsigned BIT_W  = $clog2(WORD_W);
    localparam int unsigned SLOT_W = $clog2(WORDS);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_BITS - 1);

    typedef struct packed {
        logic              active;
        logic [CNT_W-1:0]  cnt;
        logic [WORD_W-1:0] shift;
        logic [REG_W-1:0]  word;
        logic              irq;
        logic [SLOT_W-1:0] slot;
        logic              unread;
        logic              ovr;
    } rx_state_t;

    rx_state_t rx_d, rx_q;
    logic [WORD_W-1:0] shifted;

    always_comb begin
        rx_d     = rx_q;
        rx_d.irq = 1'b0;
        rx_d.ovr = 1'b0;
        shifted  = {rx_q.shift[WORD_W-2:0], sd};
        if (rd) begin
            rx_d.unread = 1'b0;
        end
        if (bit_rise) begin
            if (!rx_q.active) begin
                if (fs_low) begin
                    rx_d.active = 1'b1;
                    rx_d.cnt    = '0;
                end
            end else begin
                rx_d.shift = shifted;
                rx_d.cnt   = rx_q.cnt + 1'b1;
                if (rx_q.cnt[BIT_W-1:0] == '1) begin
                    rx_d.word   = {{(REG_W-WORD_W){shifted[WORD_W-1]}}, shifted};
                    rx_d.irq    = 1'b1;
                    rx_d.slot   = rx_q.cnt[CNT_W-1:BIT_W];
                    rx_d.ovr    = rx_q.unread && !rd;
                    rx_d.unread = 1'b1;
                    if (rx_q.cnt == LAST) begin
                        rx_d.active = 1'b0;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rx_q <= '0;
        else        rx_q <= rx_d;
    end

    assign word    = rx_q.word;
    assign irq     = rx_q.irq;
    assign slot    = rx_q.slot;
    assign overrun = rx_q.ovr;

    assert_irq_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rx_q.irq |=> !rx_q.irq);
    assert_ovr_with_irq_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rx_q.ovr |-> rx_q.irq);
    assert_word_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_q.irq |-> $stable(rx_q.word));
endmodule

// File: rtl/sap_tx.sv
module sap_tx #(
    parameter int unsigned WORD_W = 16,
    parameter int unsigned WORDS  = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_rise,
    input  logic fs_low,
    input  logic wr,
    input  logic [WORD_W-1:0] wdata,
    output logic sd,
    output logic underrun
);
    localparam int unsigned FRAME_BITS = WORD_W * WORDS;
    localparam int unsigned CNT_W = $clog2(FRAME_BITS);
    localparam int unsigned BIT_W = $clog2(WORD_W);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_BITS - 1);

    typedef struct packed {
        logic              active;
        logic [CNT_W-1:0]  cnt;
        logic [WORD_W-1:0] shift;
        logic [WORD_W-1:0] hold;
        logic              fresh;
        logic              unr;
    } tx_state_t;

    tx_state_t tx_d, tx_q;
    logic load;

    always_comb begin
        tx_d     = tx_q;
        tx_d.unr = 1'b0;
        load     = 1'b0;
        if (bit_rise) begin
            if (!tx_q.active) begin
                if (fs_low) begin
                    tx_d.active = 1'b1;
                    tx_d.cnt    = '0;
                    load        = 1'b1;
                end
            end else begin
                tx_d.cnt   = tx_q.cnt + 1'b1;
                tx_d.shift = tx_q.shift << 1;
                if (tx_q.cnt == LAST) begin
                    tx_d.active = 1'b0;
                end else if (tx_q.cnt[BIT_W-1:0] == '1) begin
                    load = 1'b1;
                end
            end
        end
        if (load) begin
            tx_d.shift = tx_q.hold;
            tx_d.unr   = !tx_q.fresh;
            tx_d.fresh = 1'b0;
        end
        if (wr) begin
            tx_d.hold  = wdata;
            tx_d.fresh = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tx_q <= '0;
        else        tx_q <= tx_d;
    end

    assign sd       = tx_q.active & tx_q.shift[WORD_W-1];
    assign underrun = tx_q.unr;

    assert_underrun_in_frame_R7: assert property (@(posedge clk) disable iff (!rst_n)
        tx_q.unr |-> tx_q.active);
    assert_underrun_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        tx_q.unr |=> !tx_q.unr);
endmodule

// File: rtl/sap_port.sv
module sap_port
    import sap_pkg::*;
#(
    parameter int unsigned WORD_W = SAMPLE_W,
    parameter int unsigned REG_W  = RXREG_W,
    parameter int unsigned WORDS  = SLOTS
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     bclk,
    input  logic                     rx_fs_n,
    input  logic                     tx_fs_n,
    input  logic                     adc_sd,
    output logic                     dac_sd,
    input  logic                     tx_wr,
    input  logic [WORD_W-1:0]        tx_data,
    input  logic                     rx_rd,
    output logic [REG_W-1:0]         rx_data,
    output logic                     rx_irq,
    output logic [$clog2(WORDS)-1:0] rx_slot,
    output logic                     rx_overrun,
    output logic                     tx_underrun
);
    logic [3:0] pins_s;
    logic bclk_s, rx_fs_s, tx_fs_s, adc_s;

    typedef struct packed {
        logic bclk_prev;
    } edge_state_t;

    edge_state_t edge_d, edge_q;
    logic bit_rise;

    sap_sync #(
        .W       (4),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (4'b0110)
    ) i_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({bclk, rx_fs_n, tx_fs_n, adc_sd}),
        .sync_out (pins_s)
    );

    assign {bclk_s, rx_fs_s, tx_fs_s, adc_s} = pins_s;

    always_comb begin
        edge_d           = edge_q;
        edge_d.bclk_prev = bclk_s;
        bit_rise         = bclk_s & ~edge_q.bclk_prev;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) edge_q <= '0;
        else        edge_q <= edge_d;
    end

    sap_rx #(
        .WORD_W (WORD_W),
        .REG_W  (REG_W),
        .WORDS  (WORDS)
    ) i_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .bit_rise (bit_rise),
        .fs_low   (~rx_fs_s),
        .sd       (adc_s),
        .rd       (rx_rd),
        .word     (rx_data),
        .irq      (rx_irq),
        .slot     (rx_slot),
        .overrun  (rx_overrun)
    );

    sap_tx #(
        .WORD_W (WORD_W),
        .WORDS  (WORDS)
    ) i_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .bit_rise (bit_rise),
        .fs_low   (~tx_fs_s),
        .wr       (tx_wr),
        .wdata    (tx_data),
        .sd       (dac_sd),
        .underrun (tx_underrun)
    );

    assert_rise_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        bit_rise |=> !bit_rise);
endmodule

// File: tb/test_sap_port.sv
`timescale 1ns/1ps
module test_sap_port;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bclk = 1'b0, rx_fs_n = 1'b1, tx_fs_n = 1'b1, adc_sd = 1'b0;
    logic dac_sd;
    logic tx_wr = 1'b0;
    logic [15:0] tx_data = '0;
    logic rx_rd;
    logic [31:0] rx_data;
    logic rx_irq;
    logic [0:0] rx_slot;
    logic rx_overrun, tx_underrun;

    logic auto_rd_q = 1'b0;
    logic manual_rd = 1'b0;
    logic auto_read = 1'b1;
    assign rx_rd = auto_rd_q | manual_rd;

    int n_checks = 0;
    int n_fail = 0;
    int unr_seen = 0;
    int unr_exp = 0;

    typedef struct packed {
        logic [31:0] data;
        logic        slot;
        logic        ovr;
    } exp_t;
    exp_t rxq[$];

    logic [15:0] model_hold = '0;
    logic        model_fresh = 1'b0;
    logic        model_unread = 1'b0;
    logic [31:0] prev_rx;
    logic        prev_irq;

    always #2.5 clk = ~clk;

    sap_port i_sap_port (
        .clk(clk), .rst_n(rst_n), .bclk(bclk), .rx_fs_n(rx_fs_n), .tx_fs_n(tx_fs_n),
        .adc_sd(adc_sd), .dac_sd(dac_sd), .tx_wr(tx_wr), .tx_data(tx_data),
        .rx_rd(rx_rd), .rx_data(rx_data), .rx_irq(rx_irq), .rx_slot(rx_slot),
        .rx_overrun(rx_overrun), .tx_underrun(tx_underrun)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    function automatic logic [31:0] sext(input logic [15:0] v);
        return {{16{v[15]}}, v};
    endfunction

    // Monitor: pops the scoreboard on every receive pulse
    always @(negedge clk) begin
        if (rst_n) begin
            if (rx_irq) begin
                if (rxq.size() == 0) begin
                    check("R8 unexpected rx_irq", 32'd1, 32'd0);
                end else begin
                    exp_t e;
                    e = rxq.pop_front();
                    check("R2/R3 rx_data", rx_data, e.data);
                    check("R4 rx_slot", {31'd0, rx_slot}, {31'd0, e.slot});
                    check("R5 rx_overrun", {31'd0, rx_overrun}, {31'd0, e.ovr});
                end
                if (prev_irq) check("R4 irq width", 32'd2, 32'd1);
                auto_rd_q <= auto_read;
            end else begin
                auto_rd_q <= 1'b0;
                if (rx_data !== prev_rx) check("R9 rx_data moved without irq", rx_data, prev_rx);
            end
            if (tx_underrun) unr_seen++;
            prev_rx  <= rx_data;
            prev_irq <= rx_irq;
        end else begin
            prev_rx  <= '0;
            prev_irq <= 1'b0;
        end
    end

    task automatic bit_period(input logic fs, input logic d, output logic seen);
        bclk = 1'b0; rx_fs_n = fs; tx_fs_n = fs; adc_sd = d;
        #40;
        bclk = 1'b1;
        seen = dac_sd;
        #40;
    endtask

    task automatic write_tx(input logic [15:0] v);
        tx_data = v; tx_wr = 1'b1;
        model_hold = v; model_fresh = 1'b1;
        #5;
        tx_wr = 1'b0;
    endtask

    task automatic model_load(output logic [15:0] w);
        w = model_hold;
        if (!model_fresh) unr_exp++;
        model_fresh = 1'b0;
    endtask

    task automatic push_rx(input logic [15:0] v, input logic s);
        exp_t e;
        e.data = sext(v); e.slot = s; e.ovr = model_unread;
        model_unread = !auto_read;
        rxq.push_back(e);
    endtask

    task automatic run_frame(input logic [15:0] adc_l, input logic [15:0] adc_r,
                             input logic wr_r, input logic [15:0] txr);
        logic seen;
        logic [15:0] exp_l, exp_r, got_l, got_r;
        push_rx(adc_l, 1'b0);
        push_rx(adc_r, 1'b1);
        bit_period(1'b0, 1'b0, seen);
        model_load(exp_l);
        for (int k = 1; k <= 32; k++) begin
            if (k == 16) model_load(exp_r);
            bit_period(1'b1, (k <= 16) ? adc_l[16-k] : adc_r[32-k], seen);
            if (k <= 16) got_l[16-k] = seen;
            else         got_r[32-k] = seen;
            if (k == 4 && wr_r) write_tx(txr);
        end
        check("R6 dac left word", {16'd0, got_l}, {16'd0, exp_l});
        check("R6/R7 dac right word", {16'd0, got_r}, {16'd0, exp_r});
        for (int k = 0; k < 2; k++) begin
            bit_period(1'b1, 1'b0, seen);
            check("R8 dac idle after frame", {31'd0, seen}, 32'd0);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        #2000000;
        n_checks++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        logic seen;
        #20;
        check("R1 rx_data reset", rx_data, 32'd0);
        check("R1 flags reset", {28'd0, rx_irq, rx_overrun, tx_underrun, dac_sd}, 32'd0);
        #30 rst_n = 1'b1;
        #50;
        // R8: idle bit clocks, syncs high
        for (int k = 0; k < 6; k++) begin
            bit_period(1'b1, k[0], seen);
            check("R8 dac idle", {31'd0, seen}, 32'd0);
        end
        // R2 R3 R6: extremes of the sample range
        write_tx(16'h1234);
        run_frame(16'h7FFF, 16'h8000, 1'b1, 16'h8001);
        write_tx(16'hA5A5);
        run_frame(16'hC3C3, 16'h0001, 1'b1, 16'h0F0F);
        // R7: right word not written, then nothing written
        write_tx(16'h5555);
        run_frame(16'h0F1E, 16'hF00D, 1'b0, 16'h0000);
        run_frame(16'h2468, 16'h9ACE, 1'b0, 16'h0000);
        // R5: withhold reads across two frames
        auto_read = 1'b0;
        write_tx(16'h1111);
        run_frame(16'h1111, 16'hFFFE, 1'b1, 16'h2222);
        write_tx(16'h3333);
        run_frame(16'h4321, 16'hBEEF, 1'b1, 16'h4444);
        #100;
        check("R5 newest word kept", rx_data, sext(16'hBEEF));
        manual_rd = 1'b1; #5; manual_rd = 1'b0;
        model_unread = 1'b0;
        auto_read = 1'b1;
        write_tx(16'hFACE);
        run_frame(16'h8001, 16'h7FFE, 1'b1, 16'hCAFE);
        #200;
        check("R4 all words reported", rxq.size(), 32'd0);
        check("R7 underrun pulse count", unr_seen, unr_exp);
        finish_run();
    end
endmodule